// File: doc/BRIEF.md
# DRAM Low-Power Mode Sequencer

This block stands between a client's request/acknowledge handshake and the unit that sends commands to a DRAM device. It moves the memory into and out of two low-power conditions: precharge power-down and self-refresh. It issues one-cycle command strobes for each clock-enable transition and for auto-refresh. It also raises an acknowledge for each mode. Each acknowledge stays high for as long as the memory is actually in that mode, or is still inside the recovery window that follows leaving it.

The client holds a mode by keeping its request high. A periodic refresh tick from an external interval timer is stored as a pending refresh. If the tick arrives during power-down, the sequencer leaves power-down, refreshes, and goes back in on its own. If it arrives during self-refresh, the refresh waits until the exit completes.

All timing limits are parameters:
- the minimum dwell between clock-enable changes,
- the power-down exit recovery,
- the self-refresh exit recovery,
- the refresh cycle time.

Every output is registered.

Top module: `lp_mode_seq`

## Requirements
- R1: In the active state, with init done, bank idle, no recovery window running, dwell met, no pending refresh, power-down requested and self-refresh not requested, `pdEnterCmd` pulses for one cycle, and `pdAck` rises in that same cycle.
- R2: While `pdReq` stays high and no refresh is pending, no exit strobe is issued and `pdAck` stays high.
- R3: A refresh tick during power-down causes `pdExitCmd`. `pdAck` then falls after the T_XP window. One cycle later `arefCmd` pulses. Power-down is entered again T_RFC cycles after the refresh if `pdReq` is still high.
- R4: Dropping `pdReq` causes `pdExitCmd` once the dwell allows it. `pdAck` stays high through the following T_XP cycles and falls in the cycle after them.
- R5: Self-refresh entry follows the same gating as R1, with `srEnterCmd` and `srAck`. When both requests are high, self-refresh is chosen.
- R6: Dropping `srReq` causes `srExitCmd` once the dwell allows it. `srAck` stays high through the following T_XS cycles and falls in the cycle after them.
- R7: No entry and no refresh is issued while `initDone` is low or `bankIdle` is low.
- R8: Two clock-enable strobes (the entry and exit strobes of either mode) are at least T_CKE cycles apart.
- R9: After a power-down exit, a self-refresh exit or an auto-refresh, the next strobe comes no sooner than T_XP, T_XS or T_RFC cycles later, respectively.
- R10: A request for one mode is ignored while the other mode's acknowledge is high. The two acknowledges are never high together.
- R11: No `arefCmd` is issued while `srAck` is high. Ticks seen during that time produce one refresh right after `srAck` falls. Ticks that arrive before a refresh is issued merge into one refresh. A tick in the active state with no request also produces a refresh.
- R12: Reset returns the block to the active state with all outputs low. At most one command strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pdReq | input | 1 | Power-down request (level) |
| srReq | input | 1 | Self-refresh request (level) |
| initDone | input | 1 | Memory initialization complete |
| bankIdle | input | 1 | All banks precharged and idle |
| refTick | input | 1 | One-cycle pulse: a refresh is due |
| pdAck | output | 1 | Memory in power-down or its exit window |
| srAck | output | 1 | Memory in self-refresh or its exit window |
| pdEnterCmd | output | 1 | Strobe: enter power-down |
| pdExitCmd | output | 1 | Strobe: exit power-down |
| srEnterCmd | output | 1 | Strobe: enter self-refresh |
| srExitCmd | output | 1 | Strobe: exit self-refresh |
| arefCmd | output | 1 | Strobe: auto-refresh |

## Verification
The bench builds the block with T_CKE=3, T_XP=2, T_XS=4 and T_RFC=3. With these values every dwell and recovery window closes within a few cycles. A per-cycle table can then cover a full power-down refresh excursion, a self-refresh with a deferred refresh, and requests that cross modes, and check the exact cycle each acknowledge falls. Separate directed steps cover reset from inside self-refresh, refresh held back by a busy bank, and two ticks merging into one refresh.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_PD     = 3'd1,
    ST_PDX    = 3'd2,
    ST_SR     = 3'd3,
    ST_SRX    = 3'd4
  } lpState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic ckeLoad;
    logic loadXp;
    logic loadXs;
    logic loadRfc;
    logic refTake;
  } lpCtl_t;

  // datapath -> control status
  typedef struct packed {
    logic ckeOk;
    logic guardOk;
    logic refPend;
  } lpStat_t;

  typedef struct packed {
    logic pdEnter;
    logic pdExit;
    logic srEnter;
    logic srExit;
    logic aref;
  } lpCmd_t;

endpackage

// File: rtl/lp_seq_dpath.sv
module lp_seq_dpath
  import lp_seq_pkg::*;
#(
  parameter int T_CKE = 4,
  parameter int T_XP  = 4,
  parameter int T_XS  = 128,
  parameter int T_RFC = 104
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    refTick,
  input  lpCtl_t  ctl,
  output lpStat_t stat
);

  localparam int GMAX_A = (T_XS > T_XP) ? T_XS : T_XP;
  localparam int GMAX   = (GMAX_A > T_RFC) ? GMAX_A : T_RFC;
  localparam int CW     = $clog2(T_CKE + 1);
  localparam int GW     = $clog2(GMAX + 1);
  localparam logic [CW-1:0] CKE_SAT  = CW'(T_CKE);
  localparam logic [GW-1:0] XP_LOAD  = GW'(T_XP - 1);
  localparam logic [GW-1:0] XS_LOAD  = GW'(T_XS - 1);
  localparam logic [GW-1:0] RFC_LOAD = GW'(T_RFC - 1);

  logic [CW-1:0] ckeCnt;
  logic [GW-1:0] guardCnt;
  logic          refPend;

  // cycles since the last clock-enable change, saturating
  always_ff @(posedge clk) begin
    if (rst)                   ckeCnt <= CKE_SAT;
    else if (ctl.ckeLoad)      ckeCnt <= CW'(1);
    else if (ckeCnt < CKE_SAT) ckeCnt <= ckeCnt + CW'(1);
  end

  // recovery window after exits and refresh
  always_ff @(posedge clk) begin
    if (rst)                  guardCnt <= '0;
    else if (ctl.loadXp)      guardCnt <= XP_LOAD;
    else if (ctl.loadXs)      guardCnt <= XS_LOAD;
    else if (ctl.loadRfc)     guardCnt <= RFC_LOAD;
    else if (guardCnt != '0)  guardCnt <= guardCnt - GW'(1);
  end

  // pending refresh: new tick wins over a take in the same cycle
  always_ff @(posedge clk) begin
    if (rst) refPend <= 1'b0;
    else     refPend <= refTick | (refPend & ~ctl.refTake);
  end

  assign stat.ckeOk   = (ckeCnt == CKE_SAT);
  assign stat.guardOk = (guardCnt == '0);
  assign stat.refPend = refPend;

  AST_CKE_DWELL: assert property (@(posedge clk) disable iff (rst)
    ctl.ckeLoad |-> ckeCnt == CKE_SAT); // R8
  AST_GUARD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ctl.ckeLoad || ctl.loadRfc) |-> guardCnt == '0); // R9
  AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (rst)
    ctl.refTake |-> refPend); // R11
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.loadXp, ctl.loadXs, ctl.loadRfc})); // R12

endmodule

// File: rtl/lp_seq_ctrl.sv
module lp_seq_ctrl
  import lp_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    pdReq,
  input  logic    srReq,
  input  logic    initDone,
  input  logic    bankIdle,
  input  lpStat_t stat,
  output lpCtl_t  ctl,
  output logic    pdAck,
  output logic    srAck,
  output logic    pdEnterCmd,
  output logic    pdExitCmd,
  output logic    srEnterCmd,
  output logic    srExitCmd,
  output logic    arefCmd
);

  lpState_t st, stNxt;
  lpCmd_t   cmdQ, cmdNxt;
  logic     pdAckNxt, srAckNxt;
  logic     canCmd;

  assign canCmd = initDone & bankIdle & stat.guardOk;

  always_comb begin
    stNxt    = st;
    pdAckNxt = pdAck;
    srAckNxt = srAck;
    cmdNxt   = '0;
    ctl      = '0;
    case (st)
      ST_ACTIVE: begin
        if (canCmd) begin
          if (stat.refPend) begin
            cmdNxt.aref = 1'b1;
            ctl.loadRfc = 1'b1;
            ctl.refTake = 1'b1;
          end else if (stat.ckeOk && srReq) begin
            cmdNxt.srEnter = 1'b1;
            ctl.ckeLoad    = 1'b1;
            srAckNxt       = 1'b1;
            stNxt          = ST_SR;
          end else if (stat.ckeOk && pdReq) begin
            cmdNxt.pdEnter = 1'b1;
            ctl.ckeLoad    = 1'b1;
            pdAckNxt       = 1'b1;
            stNxt          = ST_PD;
          end
        end
      end
      ST_PD: begin
        if (stat.ckeOk && (!pdReq || stat.refPend)) begin
          cmdNxt.pdExit = 1'b1;
          ctl.ckeLoad   = 1'b1;
          ctl.loadXp    = 1'b1;
          stNxt         = ST_PDX;
        end
      end
      ST_PDX: begin
        if (stat.guardOk) begin
          pdAckNxt = 1'b0;
          stNxt    = ST_ACTIVE;
        end
      end
      ST_SR: begin
        if (stat.ckeOk && !srReq) begin
          cmdNxt.srExit = 1'b1;
          ctl.ckeLoad   = 1'b1;
          ctl.loadXs    = 1'b1;
          stNxt         = ST_SRX;
        end
      end
      ST_SRX: begin
        if (stat.guardOk) begin
          srAckNxt = 1'b0;
          stNxt    = ST_ACTIVE;
        end
      end
      default: stNxt = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_ACTIVE;
      cmdQ  <= '0;
      pdAck <= 1'b0;
      srAck <= 1'b0;
    end else begin
      st    <= stNxt;
      cmdQ  <= cmdNxt;
      pdAck <= pdAckNxt;
      srAck <= srAckNxt;
    end
  end

  assign pdEnterCmd = cmdQ.pdEnter;
  assign pdExitCmd  = cmdQ.pdExit;
  assign srEnterCmd = cmdQ.srEnter;
  assign srExitCmd  = cmdQ.srExit;
  assign arefCmd    = cmdQ.aref;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pdEnterCmd, pdExitCmd, srEnterCmd, srExitCmd, arefCmd})); // R12
  AST_ACKS_APART: assert property (@(posedge clk) disable iff (rst)
    !(pdAck && srAck)); // R10
  AST_NO_REF_IN_SR: assert property (@(posedge clk) disable iff (rst)
    srAck |-> !arefCmd); // R11
  AST_INIT_GATE: assert property (@(posedge clk) disable iff (rst)
    (pdEnterCmd || srEnterCmd || arefCmd) |-> ($past(initDone) && $past(bankIdle))); // R7
  AST_PD_ENTER_ACK: assert property (@(posedge clk) disable iff (rst)
    pdEnterCmd |-> (pdAck && !$past(pdAck))); // R1
  AST_SR_ENTER_ACK: assert property (@(posedge clk) disable iff (rst)
    srEnterCmd |-> (srAck && !$past(srAck))); // R5
  AST_PD_EXIT_ACK: assert property (@(posedge clk) disable iff (rst)
    pdExitCmd |=> pdAck); // R4
  AST_SR_EXIT_ACK: assert property (@(posedge clk) disable iff (rst)
    srExitCmd |=> srAck); // R6

endmodule

// File: rtl/lp_mode_seq.sv
module lp_mode_seq
  import lp_seq_pkg::*;
#(
  parameter int T_CKE = 4,
  parameter int T_XP  = 4,
  parameter int T_XS  = 128,
  parameter int T_RFC = 104
) (
  input  logic clk,
  input  logic rst,
  input  logic pdReq,
  input  logic srReq,
  input  logic initDone,
  input  logic bankIdle,
  input  logic refTick,
  output logic pdAck,
  output logic srAck,
  output logic pdEnterCmd,
  output logic pdExitCmd,
  output logic srEnterCmd,
  output logic srExitCmd,
  output logic arefCmd
);

  lpCtl_t  ctl;
  lpStat_t stat;

  lp_seq_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .pdReq      (pdReq),
    .srReq      (srReq),
    .initDone   (initDone),
    .bankIdle   (bankIdle),
    .stat       (stat),
    .ctl        (ctl),
    .pdAck      (pdAck),
    .srAck      (srAck),
    .pdEnterCmd (pdEnterCmd),
    .pdExitCmd  (pdExitCmd),
    .srEnterCmd (srEnterCmd),
    .srExitCmd  (srExitCmd),
    .arefCmd    (arefCmd)
  );

  lp_seq_dpath #(
    .T_CKE (T_CKE),
    .T_XP  (T_XP),
    .T_XS  (T_XS),
    .T_RFC (T_RFC)
  ) dpath_i (
    .clk     (clk),
    .rst     (rst),
    .refTick (refTick),
    .ctl     (ctl),
    .stat    (stat)
  );

endmodule

// File: tb/lp_mode_seq_tb_top.sv
`timescale 1ns/1ps
module lp_mode_seq_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pdReq = 1'b0, srReq = 1'b0, initDone = 1'b0, bankIdle = 1'b0, refTick = 1'b0;
  logic pdAck, srAck, pdEnterCmd, pdExitCmd, srEnterCmd, srExitCmd, arefCmd;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lp_mode_seq #(.T_CKE(3), .T_XP(2), .T_XS(4), .T_RFC(3)) dut_i (
    .clk(clk), .rst(rst), .pdReq(pdReq), .srReq(srReq), .initDone(initDone),
    .bankIdle(bankIdle), .refTick(refTick), .pdAck(pdAck), .srAck(srAck),
    .pdEnterCmd(pdEnterCmd), .pdExitCmd(pdExitCmd), .srEnterCmd(srEnterCmd),
    .srExitCmd(srExitCmd), .arefCmd(arefCmd)
  );

  // row: {pdReq,srReq,initDone,bankIdle,refTick, pdAck,srAck,pdEnter,pdExit,srEnter,srExit,aref}
  localparam int NROW = 36;
  localparam logic [11:0] VEC [NROW] = '{
    12'b10010_0000000, 12'b10100_0000000, 12'b10110_1010000, 12'b10110_1000000,
    12'b10111_1000000, 12'b10110_1001000, 12'b10110_1000000, 12'b10110_0000000,
    12'b10110_0000001, 12'b10110_0000000, 12'b10110_0000000, 12'b10110_1010000,
    12'b00110_1000000, 12'b00110_1000000, 12'b00110_1001000, 12'b01110_1000000,
    12'b01110_0000000, 12'b11110_0100100, 12'b11111_0100000, 12'b11110_0100000,
    12'b10110_0100010, 12'b10110_0100000, 12'b10110_0100000, 12'b10110_0100000,
    12'b10110_0000000, 12'b10110_0000001, 12'b10110_0000000, 12'b10110_0000000,
    12'b10110_1010000, 12'b11110_1000000, 12'b11110_1000000, 12'b01110_1001000,
    12'b01110_1000000, 12'b01110_0000000, 12'b01110_0100100, 12'b00110_0100000
  };

  function automatic string rowReq(input int i);
    case (i)
      0, 1:           return "R7";
      2, 3:           return "R1";
      4, 5, 7, 8, 11: return "R3";
      6, 9, 10:       return "R9";
      12, 13, 35:     return "R8";
      14, 31, 32, 33: return "R4";
      15, 16, 28:     return "R10";
      17, 34:         return "R5";
      18, 19, 25:     return "R11";
      26, 27:         return "R9";
      29, 30:         return "R2";
      default:        return "R6";
    endcase
  endfunction

  function automatic logic [6:0] outVec();
    return {pdAck, srAck, pdEnterCmd, pdExitCmd, srEnterCmd, srExitCmd, arefCmd};
  endfunction

  task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12", outVec(), 7'b0);   // reset state
    rst = 1'b0;

    for (int i = 0; i < NROW; i++) begin
      {pdReq, srReq, initDone, bankIdle, refTick} = VEC[i][11:7];
      @(negedge clk);
      check(rowReq(i), outVec(), VEC[i][6:0]);
    end

    // R12: reset from inside self-refresh
    rst = 1'b1; pdReq = 1'b0; srReq = 1'b0; refTick = 1'b0;
    @(negedge clk);
    check("R12", outVec(), 7'b0);
    rst = 1'b0;

    // R7: a due refresh waits while the bank is busy
    initDone = 1'b1; bankIdle = 1'b0; refTick = 1'b1;
    @(negedge clk);
    refTick = 1'b0;
    repeat (2) @(negedge clk);
    check("R7", {6'b0, arefCmd}, 7'b0);

    // R11: second tick merges; refresh once the bank frees up
    refTick = 1'b1;
    @(negedge clk);
    refTick = 1'b0; bankIdle = 1'b1;
    @(negedge clk);
    check("R11", outVec(), 7'b0000001);
    begin
      int extra = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (arefCmd) extra++;
      end
      check("R11", 7'(extra), 7'd0);
    end
    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

endmodule